// File: doc/BRIEF.md
# TDM Serial Input Deserializer with Whole-Bit and Fractional Delay

The block takes one serial time-division-multiplexed line and turns it into a stream of 8-bit channel bytes, each tagged with its channel number. A frame pulse marks the frame boundary. The block runs on an oversampling clock: each bit lasts four clock ticks at the three lower line rates and two ticks at the fastest rate. After each frame boundary it counts ticks and bit periods. It takes one sample per bit at a selectable point inside the bit and assembles the samples, most significant bit first, into channel bytes. It stops after the last channel that the selected rate carries.

Two settings shift the point where bits are taken. A 3-bit whole-bit delay moves the whole frame later by 0 to 7 bit periods, so that streams with different wire delays can be aligned. A 2-bit sampling-point code picks the sub-bit position of the sample. At the fastest rate only half-bit positions exist, and the code is rounded to the nearest one. A downstream switch consumes the one-cycle byte strobe together with the data and the channel number.

Top module: `tdm_deser`

## Requirements
- R1: While reset is asserted and after it is released, `byte_valid` is 0 and `byte_data` and `chan_idx` are 0 until the first byte is complete.
- R2: A frame boundary is the clock edge at which `frame_pulse` is sampled 1 after being sampled 0. The first clock cycle after that edge is tick 0 of bit period 0. A new boundary restarts the count at any time.
- R3: Bits arrive most significant first. With zero delay, bit 7 of channel 0 occupies bit period 0, and bits 7 down to 0 of channel c occupy bit periods 8c to 8c+7.
- R4: A whole-bit delay `bit_delay` = N (0 to 7) moves every data bit N bit periods later. The line content in bit periods 0 to N-1 is ignored.
- R5: `rate_sel` codes 0, 1, 2 and 3 select rates with 32, 64, 128 and 256 channels. Codes 0 to 2 use 4 clock ticks per bit and code 3 uses 2.
- R6: At rate codes 0 to 2, `samp_pt` codes 0, 1, 2 and 3 take the sample at 1/4, 2/4, 3/4 and 4/4 of the bit, which is tick 0, 1, 2 or 3 of that bit period. The line value at the other ticks has no effect.
- R7: At rate code 3, `samp_pt` codes 0, 1 and 2 take the sample at the 1/2 point (tick 0), and code 3 takes it at the full-bit point (tick 1). So the 3/4 code, which is the usual setting at the lower rates, becomes the 1/2 point.
- R8: After bit 0 of the last channel (31, 63, 127 or 255) no further byte is produced until the next frame boundary.
- R9: `byte_valid` is high for exactly one clock, in the cycle after the sampling edge of a channel's bit 0, with that channel's byte on `byte_data` and its number on `chan_idx`. Both outputs hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_pulse | input | 1 | Frame pulse; a 0-to-1 transition marks the boundary |
| sdi | input | 1 | Serial TDM data line |
| rate_sel | input | 2 | Line rate code 0..3 |
| bit_delay | input | 3 | Whole-bit input delay, 0..7 bit periods |
| samp_pt | input | 2 | Sampling point code, quarter-bit steps |
| byte_valid | output | 1 | One-cycle strobe for a completed channel byte |
| byte_data | output | 8 | Assembled channel byte, MSB received first |
| chan_idx | output | 8 | Channel number of the byte |

## Verification
The bench drives the correct bit value only at the tick where the requirements say the sample is taken, and drives the inverted value at every other tick of the bit. A design with the wrong tick, the wrong ticks per bit, or the wrong half-bit rounding at the fastest rate therefore produces inverted bits rather than a subtle shift. Delays of 0, 3, 5 and 7 bits fill the skipped periods with toggling junk. An off-by-one in the delay shows up as bytes that are rotated by one bit. The bench also runs idle cycles after each frame and treats any strobe with no expected byte as a failure, which catches a channel counter that overruns the last channel of the selected rate or wraps back to channel 0.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;

  // ticks per bit period at the lower rates and at the fastest rate
  localparam int TPB_SLOW = 4;
  localparam int TPB_FAST = 2;

  typedef enum logic [1:0] {
    SP_QUARTER = 2'd0,
    SP_HALF    = 2'd1,
    SP_3QUART  = 2'd2,
    SP_FULL    = 2'd3
  } samp_pt_e;

  // Tick inside the bit period at which the line is sampled.
  // At the fastest rate only half-bit points exist: 1/4 rounds up to 1/2,
  // 3/4 rounds down to 1/2, the full-bit point stays.
  function automatic logic [1:0] sample_tick(input logic fast, input logic [1:0] code);
    if (fast) sample_tick = (samp_pt_e'(code) == SP_FULL) ? 2'd1 : 2'd0;
    else      sample_tick = code;
  endfunction

endpackage

// File: rtl/tdm_deser_timing.sv
module tdm_deser_timing
  import tdm_deser_pkg::*;
#(
  parameter  int BASE_CH = 32,
  parameter  int N_RATES = 4,
  localparam int RW      = $clog2(N_RATES),
  localparam int IDXW    = $clog2(BASE_CH) + N_RATES - 1 + 3,
  localparam int BPW     = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_pulse,
  input  logic [RW-1:0]   rate_sel,
  input  logic [2:0]      bit_delay,
  input  logic [1:0]      samp_pt,
  output logic            samp_stb,
  output logic [IDXW-1:0] data_idx
);

  logic           fp_q;
  logic           active_q, active_d;
  logic [1:0]     tick_q, tick_d;
  logic [BPW-1:0] bp_q, bp_d;

  logic           fast;
  logic [1:0]     last_tick;
  logic [1:0]     samp_tick;
  logic [BPW-1:0] nbits;
  logic [BPW-1:0] dly;
  logic [BPW-1:0] last_bp;
  logic [BPW-1:0] rel_bp;
  logic           boundary;

  always_comb begin
    fast      = (rate_sel == RW'(N_RATES - 1));
    last_tick = fast ? 2'(TPB_FAST - 1) : 2'(TPB_SLOW - 1);
    samp_tick = sample_tick(fast, samp_pt);
    nbits     = BPW'(BASE_CH * 8) << rate_sel;
    dly       = BPW'(bit_delay);
    last_bp   = dly + nbits - BPW'(1);
    boundary  = frame_pulse & ~fp_q;
  end

  // next state
  always_comb begin
    active_d = active_q;
    tick_d   = tick_q;
    bp_d     = bp_q;
    if (boundary) begin
      active_d = 1'b1;
      tick_d   = '0;
      bp_d     = '0;
    end else if (active_q) begin
      if (tick_q == last_tick) begin
        tick_d = '0;
        if (bp_q == last_bp) active_d = 1'b0;
        else                 bp_d     = bp_q + BPW'(1);
      end else begin
        tick_d = tick_q + 2'd1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q     <= 1'b0;
      active_q <= 1'b0;
      tick_q   <= '0;
      bp_q     <= '0;
    end else begin
      fp_q     <= frame_pulse;
      active_q <= active_d;
      tick_q   <= tick_d;
      bp_q     <= bp_d;
    end
  end

  always_comb begin
    rel_bp   = bp_q - dly;
    samp_stb = active_q && (tick_q == samp_tick) && (bp_q >= dly);
    data_idx = rel_bp[IDXW-1:0];
  end

endmodule

// File: rtl/tdm_deser_shift.sv
module tdm_deser_shift #(
  parameter  int IDXW = 11,
  localparam int CHW  = IDXW - 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_stb,
  input  logic            sdi,
  input  logic [IDXW-1:0] data_idx,
  output logic            byte_valid,
  output logic [7:0]      byte_data,
  output logic [CHW-1:0]  chan_idx
);

  logic [6:0]     sh_q, sh_d;
  logic           vld_q, vld_d;
  logic [7:0]     dat_q, dat_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic           last_bit;

  always_comb begin
    last_bit = samp_stb && (data_idx[2:0] == 3'd7);
    sh_d     = samp_stb ? {sh_q[5:0], sdi} : sh_q;
    vld_d    = last_bit;
    dat_d    = last_bit ? {sh_q, sdi} : dat_q;
    ch_d     = last_bit ? data_idx[IDXW-1:3] : ch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      vld_q <= 1'b0;
      dat_q <= '0;
      ch_q  <= '0;
    end else begin
      sh_q  <= sh_d;
      vld_q <= vld_d;
      dat_q <= dat_d;
      ch_q  <= ch_d;
    end
  end

  assign byte_valid = vld_q;
  assign byte_data  = dat_q;
  assign chan_idx   = ch_q;

endmodule

// File: rtl/tdm_deser.sv
module tdm_deser #(
  parameter  int BASE_CH = 32,
  parameter  int N_RATES = 4,
  localparam int RW      = $clog2(N_RATES),
  localparam int CHW     = $clog2(BASE_CH) + N_RATES - 1,
  localparam int IDXW    = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_pulse,
  input  logic           sdi,
  input  logic [RW-1:0]  rate_sel,
  input  logic [2:0]     bit_delay,
  input  logic [1:0]     samp_pt,
  output logic           byte_valid,
  output logic [7:0]     byte_data,
  output logic [CHW-1:0] chan_idx
);

  logic            samp_stb;
  logic [IDXW-1:0] data_idx;

  tdm_deser_timing #(.BASE_CH(BASE_CH), .N_RATES(N_RATES)) u_timing (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_pulse (frame_pulse),
    .rate_sel    (rate_sel),
    .bit_delay   (bit_delay),
    .samp_pt     (samp_pt),
    .samp_stb    (samp_stb),
    .data_idx    (data_idx)
  );

  tdm_deser_shift #(.IDXW(IDXW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_stb   (samp_stb),
    .sdi        (sdi),
    .data_idx   (data_idx),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .chan_idx   (chan_idx)
  );

endmodule

// File: rtl/tdm_deser_chk.sv
module tdm_deser_chk #(
  parameter  int BASE_CH = 32,
  parameter  int N_RATES = 4,
  localparam int RW      = $clog2(N_RATES),
  localparam int CHW     = $clog2(BASE_CH) + N_RATES - 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RW-1:0]  rate_sel,
  input logic           samp_stb,
  input logic           byte_valid,
  input logic [7:0]     byte_data,
  input logic [CHW-1:0] chan_idx
);

  logic [CHW:0] chan_limit;
  assign chan_limit = (CHW + 1)'(BASE_CH) << rate_sel;

  // R9: strobe lasts one clock (bytes are at least eight samples apart)
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R9: a byte is reported only after a sampling strobe
  a_r9_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(samp_stb));

  // R9: outputs hold between strobes
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> $stable(byte_data) && $stable(chan_idx));

  // R8: channel number never exceeds the last channel of the rate
  a_r8_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ({1'b0, chan_idx} < chan_limit));

  // R1: reset values
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!byte_valid && byte_data == 8'd0);
    end
  end

endmodule

bind tdm_deser tdm_deser_chk #(.BASE_CH(BASE_CH), .N_RATES(N_RATES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rate_sel   (rate_sel),
  .samp_stb   (samp_stb),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .chan_idx   (chan_idx)
);

// File: tb/tdm_deser_tb.sv
`timescale 1ns/1ps
module tdm_deser_tb;

  logic       clk;
  logic       rst_n;
  logic       frame_pulse;
  logic       sdi;
  logic [1:0] rate_sel;
  logic [2:0] bit_delay;
  logic [1:0] samp_pt;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [7:0] chan_idx;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  logic [15:0] expq[$];   // {channel, byte}

  tdm_deser u_dut (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .sdi(sdi),
    .rate_sel(rate_sel), .bit_delay(bit_delay), .samp_pt(samp_pt),
    .byte_valid(byte_valid), .byte_data(byte_data), .chan_idx(chan_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  always @(posedge clk) cycles <= cycles + 1;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  // monitor: pop expected bytes as the design reports them (R3, R8, R9)
  always @(negedge clk) begin
    if (rst_n && byte_valid) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R8: unexpected byte ch=%0d data=%02h, expected none", chan_idx, byte_data);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        if ({chan_idx, byte_data} !== e) begin
          failures++;
          $display("FAIL R3/R9: actual ch=%0d data=%02h expected ch=%0d data=%02h",
                   chan_idx, byte_data, e[15:8], e[7:0]);
        end
      end
    end
  end

  function automatic logic [7:0] pat(int ch, int seed);
    return 8'((ch * 29 + seed * 71) ^ 8'h5A);
  endfunction

  // driver: one frame with given settings, expected items pushed first
  task automatic run_frame(input int rate, input int nd, input int sp, input int seed, input string tag);
    int tpb, nch, st, total;
    tpb = (rate == 3) ? 2 : 4;                       // R5
    nch = 32 << rate;                                 // R5, R8
    st  = (rate == 3) ? ((sp == 3) ? 1 : 0) : sp;     // R6, R7
    @(negedge clk);
    rate_sel = 2'(rate); bit_delay = 3'(nd); samp_pt = 2'(sp);
    for (int c = 0; c < nch; c++) expq.push_back({8'(c), pat(c, seed)});
    frame_pulse = 1'b1;
    @(posedge clk);                                   // boundary edge (R2)
    total = (nd + 8 * nch) * tpb;
    for (int c = 0; c < total; c++) begin
      int p, t, k;
      logic b;
      @(negedge clk);
      frame_pulse = 1'b0;
      p = c / tpb; t = c % tpb;
      if (p < nd) begin
        sdi = 1'(c & 1);                              // R4: ignored junk
      end else begin
        logic [7:0] by;
        k  = p - nd;
        by = pat(k / 8, seed);
        b  = by[7 - (k % 8)];
        sdi = (t == st) ? b : ~b;                     // R6/R7: others inverted
      end
      @(posedge clk);
    end
    for (int i = 0; i < 40; i++) begin               // R8: idle after last channel
      @(negedge clk);
      sdi = 1'(i & 1);
    end
    checks++;
    if (expq.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d bytes missing, expected 0", tag, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_pulse = 1'b0; sdi = 1'b0;
    rate_sel = '0; bit_delay = '0; samp_pt = 2'd2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (byte_valid !== 1'b0 || byte_data !== 8'd0 || chan_idx !== 8'd0) begin
      failures++;
      $display("FAIL R1: actual v=%b d=%02h c=%0d expected 0/00/0", byte_valid, byte_data, chan_idx);
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    checks++;
    if (byte_valid !== 1'b0 || byte_data !== 8'd0) begin
      failures++;
      $display("FAIL R1: after release actual v=%b d=%02h expected 0/00", byte_valid, byte_data);
    end

    run_frame(0, 0, 2, 1, "R2 rate0 delay0 3/4");
    run_frame(1, 3, 0, 2, "R4 rate1 delay3 1/4");
    run_frame(2, 7, 3, 3, "R4 rate2 delay7 4/4");
    run_frame(0, 1, 1, 4, "R6 rate0 delay1 2/4");
    run_frame(3, 0, 2, 5, "R7 rate3 code 3/4");
    run_frame(3, 5, 3, 6, "R7 rate3 code 4/4");
    run_frame(3, 2, 0, 7, "R7 rate3 code 1/4");

    repeat (20) @(negedge clk);
    summary();
  end

endmodule